// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block owns one 8-bit control register that sits behind a byte-oriented serial slave. A front end that already decodes the bus hands it one-cycle events: start, stop, an address (with its read/write direction), written data bytes, and requests for a read byte. The block decides whether each address or data byte is acknowledged, supplies the read byte, keeps the volatile enable latches, and raises a one-cycle pulse that launches the nonvolatile commit of the stored bits. An external programming engine reports the end of that commit on a completion input.

A change of the stored bits takes three separate write transactions to the register address: the first sets the write-enable latch, the second sets the register-write-enable latch, and only the third carries the new value. Each write carries a single byte and takes effect at the stop condition. Writes are refused when the write-protect pin is high and the protect-enable bit is set, and every transaction is locked out while the supervisor reset is active or a commit is still running.

Top module: `ctlreg_guard`

## Requirements
- R1: An address event equal to `REG_ADDR` that follows a start, while no commit is busy and `sup_reset_i` is low, gets a response with acknowledge one cycle later; a matching address in any other situation gets a response without acknowledge, and a non-matching address gets no response.
- R2: A write byte with bits [2:1] = 01 sets the write-enable latch (`ctl_reg_o[1]`) at its stop; a byte with bits [2:1] = 11 sets the register-write-enable latch (`ctl_reg_o[2]`) at its stop when the write-enable latch is already set; once both are set, the next written byte is stored at its stop and `commit_start_o` pulses for exactly one cycle, one cycle after the stop.
- R3: Out-of-order bytes (bits [2:1] = 11 without the write-enable latch, or bits [2:1] = 00 or 10 while not both latches are set) leave the register and the latches unchanged and start no commit.
- R4: A write transaction accepts only its first data byte; later data bytes in the same transaction get a response without acknowledge, and the first byte is still the one applied at stop.
- R5: A held byte acts only on a stop; a repeated start discards it.
- R6: When `wp_i` is high and protect-enable (`ctl_reg_o[7]`) is set, a data byte is not acknowledged and has no effect; with protect-enable clear the pin has no effect.
- R7: A read at the register address returns the register byte once on `rdata_o` with `rdata_vld_o`, one cycle after the request, and the transaction ends there; further requests produce no read byte.
- R8: While `sup_reset_i` is high the open transaction is aborted (a held byte is lost even if a stop follows), both enable latches clear, and no transaction can start.
- R9: A started commit keeps running through `sup_reset_i`; while it is busy, matching addresses are refused until `commit_done_i`, at which point both enable latches clear.
- R10: The register layout from bit 7 down to bit 0 is protect-enable, watchdog select 1, watchdog select 0, block protect 1, block protect 0, register-write-enable, write-enable, block protect 2; a commit changes only the nonvolatile bits (mask F9h) and bits [2:1] of the written byte are not stored.
- R11: After `rst_n` the register reads `NV_INIT` masked with F9h, the latches are clear and no response, read byte or commit pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| sup_reset_i | input | 1 | Supervisor reset active, locks out transactions |
| wp_i | input | 1 | Write-protect pin |
| start_i | input | 1 | Start or repeated start event |
| stop_i | input | 1 | Stop event |
| addr_vld_i | input | 1 | Address event |
| addr_i | input | ADDR_W | Decoded address |
| dir_rd_i | input | 1 | Direction of the address event, 1 = read |
| wdata_vld_i | input | 1 | Written data byte event |
| wdata_i | input | 8 | Written data byte |
| rdreq_i | input | 1 | Request for a read byte |
| commit_done_i | input | 1 | Nonvolatile commit finished |
| rsp_vld_o | output | 1 | A response to the last address or data event is present |
| rsp_ack_o | output | 1 | That response is an acknowledge |
| rdata_vld_o | output | 1 | Read byte valid |
| rdata_o | output | 8 | Read byte |
| ctl_reg_o | output | 8 | Current register contents including latches |
| commit_start_o | output | 1 | One-cycle pulse starting the nonvolatile commit |

## Verification
The bench builds the block with `ADDR_W` = 4, `REG_ADDR` = 4'hF and `NV_INIT` = 0. The narrow address makes it possible to present every address, in both directions, and check that only the register address answers. Every one of the 256 byte values goes through the full three-step sequence, commit, completion and read-back, so the masking of the stored bits is checked for each value. Directed runs then cover protection, extra bytes, repeated starts, reset lockout and a reset that lands on a busy commit.

// File: rtl/ctlg_pkg.sv
package ctlg_pkg;

  localparam int CTL_W = 8;

  localparam int B_WPEN = 7;
  localparam int B_RWEL = 2;
  localparam int B_WEL  = 1;

  localparam logic [CTL_W-1:0] NV_MASK = 8'hF9;

  typedef enum logic [2:0] {
    T_IDLE,
    T_ARMED,
    T_WR_OPEN,
    T_WR_HELD,
    T_WR_DEAD,
    T_RD_OPEN
  } txn_st_e;

  typedef enum logic [1:0] {
    L_NONE,
    L_SET_WEL,
    L_SET_RWEL,
    L_COMMIT
  } latch_act_e;

  function automatic latch_act_e latch_decode(input logic wel, input logic rwel,
                                              input logic [CTL_W-1:0] b);
    latch_act_e a;
    if (wel && rwel) begin
      a = L_COMMIT;
    end else begin
      unique case (b[B_RWEL:B_WEL])
        2'b01:   a = L_SET_WEL;
        2'b11:   a = wel ? L_SET_RWEL : L_NONE;
        default: a = L_NONE;
      endcase
    end
    return a;
  endfunction

  function automatic logic [CTL_W-1:0] merge_nv(input logic [CTL_W-1:0] old_v,
                                                input logic [CTL_W-1:0] b);
    return (old_v & ~NV_MASK) | (b & NV_MASK);
  endfunction

  function automatic logic [CTL_W-1:0] assemble(input logic [CTL_W-1:0] nv,
                                                input logic wel, input logic rwel);
    logic [CTL_W-1:0] r;
    r = nv & NV_MASK;
    r[B_RWEL] = rwel;
    r[B_WEL]  = wel;
    return r;
  endfunction

endpackage

// File: rtl/ctlg_txn.sv
module ctlg_txn
  import ctlg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_reset_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             addr_vld_i,
  input  logic             addr_hit_i,
  input  logic             dir_rd_i,
  input  logic             wdata_vld_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             rdreq_i,
  input  logic             gate_ok_i,
  input  logic             protect_i,
  output logic             rsp_vld_o,
  output logic             rsp_ack_o,
  output logic             rd_fire_o,
  output logic             apply_o,
  output logic [CTL_W-1:0] held_o
);

  txn_st_e          st, st_n;
  logic             rsp_vld_n, rsp_ack_n;
  logic [CTL_W-1:0] held, held_n;

  always_comb begin
    st_n      = st;
    rsp_vld_n = 1'b0;
    rsp_ack_n = 1'b0;
    rd_fire_o = 1'b0;
    apply_o   = 1'b0;
    held_n    = held;
    if (addr_hit_i) begin
      rsp_vld_n = 1'b1;
      rsp_ack_n = (st == T_ARMED) && gate_ok_i && !sup_reset_i;
    end
    if (sup_reset_i) begin
      st_n = T_IDLE;
    end else if (start_i) begin
      st_n = T_ARMED;
    end else if (stop_i) begin
      apply_o = (st == T_WR_HELD);
      st_n    = T_IDLE;
    end else begin
      unique case (st)
        T_ARMED: begin
          if (addr_vld_i) begin
            if (addr_hit_i && gate_ok_i) st_n = dir_rd_i ? T_RD_OPEN : T_WR_OPEN;
            else                         st_n = T_IDLE;
          end
        end
        T_WR_OPEN: begin
          if (wdata_vld_i) begin
            rsp_vld_n = 1'b1;
            if (protect_i) begin
              st_n = T_WR_DEAD;
            end else begin
              rsp_ack_n = 1'b1;
              held_n    = wdata_i;
              st_n      = T_WR_HELD;
            end
          end
        end
        T_WR_HELD, T_WR_DEAD: begin
          if (wdata_vld_i) rsp_vld_n = 1'b1;
        end
        T_RD_OPEN: begin
          if (rdreq_i) begin
            rd_fire_o = 1'b1;
            st_n      = T_IDLE;
          end
        end
        default: st_n = T_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= T_IDLE;
      held      <= '0;
      rsp_vld_o <= 1'b0;
      rsp_ack_o <= 1'b0;
    end else begin
      st        <= st_n;
      held      <= held_n;
      rsp_vld_o <= rsp_vld_n;
      rsp_ack_o <= rsp_ack_n;
    end
  end

  assign held_o = held;

endmodule

// File: rtl/ctlg_latch.sv
module ctlg_latch
  import ctlg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_reset_i,
  input  logic             apply_i,
  input  logic [CTL_W-1:0] byte_i,
  input  logic             done_i,
  input  logic             busy_i,
  output logic             wel_o,
  output logic             rwel_o,
  output logic             commit_go_o
);

  latch_act_e act;

  assign act         = latch_decode(wel_o, rwel_o, byte_i);
  assign commit_go_o = apply_i && (act == L_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
    end else if (sup_reset_i || (done_i && busy_i)) begin
      wel_o  <= 1'b0;
      rwel_o <= 1'b0;
    end else if (apply_i) begin
      if (act == L_SET_WEL)  wel_o  <= 1'b1;
      if (act == L_SET_RWEL) rwel_o <= 1'b1;
    end
  end

endmodule

// File: rtl/ctlg_commit.sv
module ctlg_commit
  import ctlg_pkg::*;
#(
  parameter logic [CTL_W-1:0] NV_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CTL_W-1:0] byte_i,
  input  logic             done_i,
  output logic [CTL_W-1:0] nv_o,
  output logic             busy_o,
  output logic             start_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_o    <= NV_INIT & NV_MASK;
      busy_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= go_i;
      if (go_i) begin
        nv_o   <= merge_nv(nv_o, byte_i);
        busy_o <= 1'b1;
      end else if (done_i) begin
        busy_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
  import ctlg_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1,
  parameter logic [7:0]       NV_INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_reset_i,
  input  logic              wp_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dir_rd_i,
  input  logic              wdata_vld_i,
  input  logic [7:0]        wdata_i,
  input  logic              rdreq_i,
  input  logic              commit_done_i,
  output logic              rsp_vld_o,
  output logic              rsp_ack_o,
  output logic              rdata_vld_o,
  output logic [7:0]        rdata_o,
  output logic [7:0]        ctl_reg_o,
  output logic              commit_start_o
);

  logic             addr_hit_w;
  logic             gate_ok_w;
  logic             protect_w;
  logic             rd_fire_w;
  logic             apply_w;
  logic [CTL_W-1:0] held_w;
  logic             wel_w, rwel_w;
  logic             commit_go_w;
  logic             busy_w;
  logic [CTL_W-1:0] nv_w;

  assign addr_hit_w = addr_vld_i && (addr_i == REG_ADDR);
  assign gate_ok_w  = !busy_w;
  assign protect_w  = wp_i && nv_w[B_WPEN];
  assign ctl_reg_o  = assemble(nv_w, wel_w, rwel_w);

  ctlg_txn u_txn (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_reset_i (sup_reset_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .addr_vld_i  (addr_vld_i),
    .addr_hit_i  (addr_hit_w),
    .dir_rd_i    (dir_rd_i),
    .wdata_vld_i (wdata_vld_i),
    .wdata_i     (wdata_i),
    .rdreq_i     (rdreq_i),
    .gate_ok_i   (gate_ok_w),
    .protect_i   (protect_w),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_ack_o   (rsp_ack_o),
    .rd_fire_o   (rd_fire_w),
    .apply_o     (apply_w),
    .held_o      (held_w)
  );

  ctlg_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_reset_i (sup_reset_i),
    .apply_i     (apply_w),
    .byte_i      (held_w),
    .done_i      (commit_done_i),
    .busy_i      (busy_w),
    .wel_o       (wel_w),
    .rwel_o      (rwel_w),
    .commit_go_o (commit_go_w)
  );

  ctlg_commit #(.NV_INIT(NV_INIT)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (commit_go_w),
    .byte_i  (held_w),
    .done_i  (commit_done_i),
    .nv_o    (nv_w),
    .busy_o  (busy_w),
    .start_o (commit_start_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_vld_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rdata_vld_o <= rd_fire_w;
      if (rd_fire_w) rdata_o <= ctl_reg_o;
    end
  end

endmodule

// File: rtl/ctlreg_guard_chk.sv
module ctlreg_guard_chk
  import ctlg_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sup_reset_i,
  input logic              wp_i,
  input logic              addr_vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wdata_vld_i,
  input logic              rsp_vld_o,
  input logic              rsp_ack_o,
  input logic              rdata_vld_o,
  input logic [7:0]        ctl_reg_o,
  input logic              commit_start_o,
  input logic              busy_w
);

  // R2: the commit pulse lasts one cycle
  a_r2_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start_o |=> !commit_start_o);

  // R3: the second latch only rises when the first was already set
  a_r3_rwel_after_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_reg_o[B_RWEL]) |-> $past(ctl_reg_o[B_WEL]));

  // R6: protected data bytes are never acknowledged
  a_r6_protect_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_vld_i && wp_i && ctl_reg_o[B_WPEN]) |=> !rsp_ack_o);

  // R7: one read byte per read transaction
  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld_o |=> !rdata_vld_o);

  // R8: supervisor reset clears both latches
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sup_reset_i |=> (ctl_reg_o[B_RWEL:B_WEL] == 2'b00));

  // R8: matching address under supervisor reset is refused
  a_r8_reset_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_reset_i && addr_vld_i && addr_i == REG_ADDR) |=> (rsp_vld_o && !rsp_ack_o));

  // R9: matching address during a busy commit is refused
  a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && addr_vld_i && addr_i == REG_ADDR) |=> (rsp_vld_o && !rsp_ack_o));

  // R10: stored bits move only together with a commit pulse
  a_r10_nv_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_reg_o & NV_MASK) |-> commit_start_o);

endmodule

bind ctlreg_guard ctlreg_guard_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sup_reset_i    (sup_reset_i),
  .wp_i           (wp_i),
  .addr_vld_i     (addr_vld_i),
  .addr_i         (addr_i),
  .wdata_vld_i    (wdata_vld_i),
  .rsp_vld_o      (rsp_vld_o),
  .rsp_ack_o      (rsp_ack_o),
  .rdata_vld_o    (rdata_vld_o),
  .ctl_reg_o      (ctl_reg_o),
  .commit_start_o (commit_start_o),
  .busy_w         (busy_w)
);

// File: tb/sim_ctlreg_guard.sv
`timescale 1ns/1ps
module sim_ctlreg_guard;

  localparam int         AW   = 4;
  localparam logic [3:0] RA   = 4'hF;
  localparam logic [7:0] MASK = 8'hF9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_reset = 0, wp = 0, start = 0, stop = 0, avld = 0, dir_rd = 0;
  logic wvld = 0, rdreq = 0, done = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rsp_vld, rsp_ack, rdata_vld, commit_start;
  logic [7:0] rdata, ctl;

  int checks = 0;
  int errors = 0;
  logic s_vld, s_ack, s_com, s_rv;
  logic [7:0] s_rd;

  always #2 clk = ~clk;

  ctlreg_guard #(.ADDR_W(AW), .REG_ADDR(RA), .NV_INIT(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_reset_i(sup_reset), .wp_i(wp),
    .start_i(start), .stop_i(stop), .addr_vld_i(avld), .addr_i(addr),
    .dir_rd_i(dir_rd), .wdata_vld_i(wvld), .wdata_i(wdata), .rdreq_i(rdreq),
    .commit_done_i(done), .rsp_vld_o(rsp_vld), .rsp_ack_o(rsp_ack),
    .rdata_vld_o(rdata_vld), .rdata_o(rdata), .ctl_reg_o(ctl),
    .commit_start_o(commit_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step();
    @(negedge clk);
    s_vld = rsp_vld; s_ack = rsp_ack; s_com = commit_start;
    s_rv = rdata_vld; s_rd = rdata;
    start = 0; stop = 0; avld = 0; wvld = 0; rdreq = 0; done = 0;
  endtask

  task automatic ev_start();  start = 1; step(); endtask
  task automatic ev_stop();   stop = 1;  step(); endtask
  task automatic ev_done();   done = 1;  step(); endtask
  task automatic ev_addr(input logic [AW-1:0] a, input logic rd);
    avld = 1; addr = a; dir_rd = rd; step();
  endtask
  task automatic ev_byte(input logic [7:0] b);
    wvld = 1; wdata = b; step();
  endtask
  task automatic ev_rdreq(); rdreq = 1; step(); endtask

  // full single-byte write; returns the data acknowledge, s_com holds stop result
  task automatic wr(input logic [7:0] b, output logic dack);
    ev_start();
    ev_addr(RA, 1'b0);
    ev_byte(b);
    dack = s_vld & s_ack;
    ev_stop();
  endtask

  logic dk;
  logic [7:0] exp_nv;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ctl", ctl, 8'h00);
    chk("R11 rsp", rsp_vld, 0);
    chk("R11 commit", commit_start, 0);
    chk("R11 rdata_vld", rdata_vld, 0);

    // R1 address sweep, both directions
    for (int a = 0; a < 16; a++) begin
      for (int d = 0; d < 2; d++) begin
        ev_start();
        ev_addr(a[AW-1:0], d[0]);
        chk("R1 vld", s_vld, (a == 15));
        chk("R1 ack", s_ack, (a == 15));
        ev_stop();
      end
    end
    ev_addr(RA, 1'b0);
    chk("R1 no start vld", s_vld, 1);
    chk("R1 no start nack", s_ack, 0);

    // R3 out-of-order bytes are ignored
    wr(8'h06, dk); chk("R3 ack 06", dk, 1); chk("R3 no commit", s_com, 0);
    chk("R3 ctl after 06", ctl, 8'h00);
    wr(8'h00, dk); chk("R3 ctl after 00", ctl, 8'h00);
    wr(8'hFC, dk); chk("R3 ctl after FC", ctl, 8'h00);

    // R2 / R10 / R9 / R7 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      wr(8'h02, dk);
      chk("R2 wel", ctl[2:1], 2'b01);
      wr(8'h06, dk);
      chk("R2 rwel", ctl[2:1], 2'b11);
      wr(v[7:0], dk);
      chk("R2 commit pulse", s_com, 1);
      exp_nv = v[7:0] & MASK;
      chk("R10 stored", ctl & MASK, exp_nv);
      @(negedge clk);
      chk("R2 pulse single", commit_start, 0);
      ev_start(); ev_addr(RA, 1'b1);
      chk("R9 busy refuse", {s_vld, s_ack}, 2'b10);
      ev_stop();
      ev_done();
      chk("R9 latches clear", ctl, exp_nv);
      ev_start(); ev_addr(RA, 1'b1);
      ev_rdreq();
      chk("R7 rdata vld", s_rv, 1);
      chk("R7 rdata", s_rd, exp_nv);
      ev_rdreq();
      chk("R7 single byte", s_rv, 0);
      ev_stop();
    end

    // R6 protection: WPEN now set (F9h)
    wp = 1;
    wr(8'h02, dk); chk("R6 nack protected", dk, 0); chk("R6 wel kept", ctl[1], 0);
    wp = 0;
    wr(8'h02, dk); chk("R6 pin low ack", dk, 1); chk("R6 wel set", ctl[1], 1);
    wp = 1;
    wr(8'h06, dk); chk("R6 rwel blocked", ctl[2], 0);
    wp = 0;
    wr(8'h06, dk); chk("R6 rwel set", ctl[2], 1);
    wp = 1;
    wr(8'h00, dk); chk("R6 data nack", dk, 0); chk("R6 no commit", s_com, 0);
    wp = 0;
    wr(8'h00, dk); chk("R6 commit", s_com, 1); chk("R6 cleared", ctl, 8'h06);
    ev_done();
    wp = 1;
    wr(8'h02, dk); chk("R6 wpen clear ack", dk, 1); chk("R6 wel with pin", ctl[1], 1);
    wp = 0;

    // R4 one byte per write
    wr(8'h06, dk);
    ev_start(); ev_addr(RA, 1'b0);
    ev_byte(8'h81); chk("R4 first ack", {s_vld, s_ack}, 2'b11);
    ev_byte(8'h18); chk("R4 second nack", {s_vld, s_ack}, 2'b10);
    ev_byte(8'h20); chk("R4 third nack", {s_vld, s_ack}, 2'b10);
    ev_stop();
    chk("R4 commit", s_com, 1); chk("R4 first byte stored", ctl & MASK, 8'h81);
    ev_done();

    // R5 repeated start discards held byte
    wr(8'h02, dk); wr(8'h06, dk);
    ev_start(); ev_addr(RA, 1'b0); ev_byte(8'h18);
    ev_start(); ev_stop();
    chk("R5 no commit", s_com, 0);
    chk("R5 unchanged", ctl, 8'h87);
    wr(8'h10, dk); chk("R5 real commit", s_com, 1); chk("R5 stored", ctl, 8'h16);
    ev_done();

    // R8 supervisor reset lockout
    wr(8'h02, dk);
    ev_start(); ev_addr(RA, 1'b0); ev_byte(8'h06);
    sup_reset = 1; step();
    chk("R8 latches cleared", ctl[2:1], 0);
    ev_start(); ev_addr(RA, 1'b0);
    chk("R8 refuse under reset", {s_vld, s_ack}, 2'b10);
    sup_reset = 0;
    ev_addr(RA, 1'b0);
    chk("R8 no txn after reset", {s_vld, s_ack}, 2'b10);
    ev_stop();
    chk("R8 no commit", s_com, 0);
    chk("R8 ctl", ctl, 8'h10);

    // R9 commit survives supervisor reset
    wr(8'h02, dk); wr(8'h06, dk); wr(8'h60, dk);
    chk("R9 commit", s_com, 1);
    sup_reset = 1; step(); sup_reset = 0;
    chk("R9 value kept", ctl, 8'h60);
    ev_start(); ev_addr(RA, 1'b0);
    chk("R9 still busy", {s_vld, s_ack}, 2'b10);
    ev_stop();
    ev_done();
    ev_start(); ev_addr(RA, 1'b0);
    chk("R9 after done", {s_vld, s_ack}, 2'b11);
    ev_stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule